// File: doc/BRIEF.md
# USB Battery-Charging Port Detection Sequencer

This block works out what kind of USB port sits at the far end of a cable once VBUS comes up. It steps through a data-contact check, a primary voltage probe and a secondary voltage probe. It then reports one of three port kinds:

- a standard downstream port (plain host);
- a charging downstream port (host that also supplies charge current);
- a dedicated charging port (wall-type charger).

The analog side sits outside the block. It supplies comparator flags, and the block drives enable lines back to the current and voltage sources. All inputs are asynchronous and are re-timed inside the block. Every time interval is a parameter counted in clock ticks.

The results are a two-bit port-type code and a one-cycle completion pulse. There are also three status lines that change on the same clock edge:

- a charger-found flag;
- an active-low charge-permit pull;
- an isolation-switch close pull.

The charge-permit and switch lines are open-drain style. A 1 on them means the pin is pulled low, and a 0 means high impedance. Losing VBUS at any point returns the block to its idle state.

Top module: `bc_charger_detect`

## Requirements
- R1: Each of the four asynchronous inputs passes through two flops. VBUS becoming valid starts contact detection on the third rising edge after the input rises. During contact detection `idp_src_en` is 1.
- R2: Contact detection ends after `DBNC_TICKS` consecutive cycles with the re-timed D+-low flag set. Any cycle with that flag clear restarts the count.
- R3: If contact is not seen within `TOUT_TICKS` cycles of entering contact detection, the block still moves on to primary detection.
- R4: Primary detection drives `vdp_src_en` for `VSRC_TICKS` cycles and then samples the D- window flag. A clear flag ends detection with code 2'b01 (standard downstream port). A set flag leads to secondary detection.
- R5: Secondary detection drives `vdm_src_en` for `VSRC_TICKS` cycles and then samples the D+ window flag. A set flag gives code 2'b11 (dedicated charging port). A clear flag gives code 2'b10 (charging downstream port).
- R6: On completion the outputs depend on the code:
  - Code 2'b11: `chg_det`=1, `sw_close_pull`=0, `vdp_src_en` stays 1.
  - Code 2'b10: `chg_det`=1, `sw_close_pull`=1.
  - Code 2'b01: `chg_det`=0, `sw_close_pull`=1.
  - In every case, `chg_allow_pull`=1, and all status outputs change on the same edge.
- R7: Before completion, `chg_det`, `chg_allow_pull` and `sw_close_pull` are 0 and `port_type` is 2'b00.
- R8: `det_done` is high for exactly one cycle, on the cycle the code first appears. The code then holds while VBUS stays valid.
- R9: Once VBUS is no longer valid, all outputs are 0 from the third rising edge after the input falls. This includes `port_type`=2'b00.
- R10: At most one of `idp_src_en`, `vdp_src_en` and `vdm_src_en` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vbus_ok_a | input | 1 | VBUS above its valid threshold (asynchronous) |
| dp_low_a | input | 1 | D+ below logic threshold (asynchronous) |
| dp_win_a | input | 1 | D+ between data reference and logic threshold (asynchronous) |
| dm_win_a | input | 1 | D- between data reference and logic threshold (asynchronous) |
| idp_src_en | output | 1 | Enable for the D+ contact-detect current source |
| vdp_src_en | output | 1 | Enable for the D+ voltage source |
| vdm_src_en | output | 1 | Enable for the D- voltage source |
| chg_det | output | 1 | Charger found (charging or dedicated port) |
| chg_allow_pull | output | 1 | 1 pulls the active-low charge-permit pin low |
| sw_close_pull | output | 1 | 1 pulls the switch-control pin low, closing the switch |
| port_type | output | 2 | 00 none, 01 standard, 10 charging downstream, 11 dedicated |
| det_done | output | 1 | One-cycle completion pulse |

## Verification
The comparator patterns are chosen so that each one can be told apart by both the resulting code and the exact completion latency:

| Pattern | Expected result |
|---|---|
| D+ held low with an empty D- window | Standard port, after debounce plus one probe |
| D+ held low with D- in its window, D+ window empty | Charging downstream port, after two probes |
| D+ held low with both windows set | Dedicated port, where the D+ source must stay on |
| D+ never low, D- window set | Timeout path ending with a charging downstream port |
| D+-low flag toggling faster than the debounce | Timeout latency, which shows the debounce counter restarts |

VBUS is also removed in the middle of a probe and after completion. In both cases every output must clear three edges later.

// File: rtl/bc_pkg.sv
package bc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONT  = 3'd1,
    ST_PRI   = 3'd2,
    ST_SEC   = 3'd3,
    ST_FINAL = 3'd4
  } bc_state_t;

  typedef enum logic [1:0] {
    PT_NONE = 2'b00,
    PT_STD  = 2'b01,
    PT_CHG  = 2'b10,
    PT_DED  = 2'b11
  } bc_port_t;

  function automatic int bc_max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bc_cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic logic bc_is_charger(input bc_port_t p);
    return (p == PT_CHG) || (p == PT_DED);
  endfunction

  function automatic logic bc_closes_switch(input bc_port_t p);
    return (p == PT_STD) || (p == PT_CHG);
  endfunction

endpackage

// File: rtl/bc_sync.sv
module bc_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_a,
  output logic [WIDTH-1:0] q_s
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        out_q  <= 1'b0;
      end else begin
        meta_q <= d_a[i];
        out_q  <= meta_q;
      end
    end
    assign q_s[i] = out_q;
  end
endmodule

// File: rtl/bc_tick_counter.sv
module bc_tick_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (clr)           count <= '0;
    else if (count != CMAX) count <= count + 1'b1;
  end

  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $past(count) == CMAX && $past(!clr)) |-> count == CMAX);
endmodule

// File: rtl/bc_charger_detect.sv
module bc_charger_detect
  import bc_pkg::*;
#(
  parameter int DBNC_TICKS = 10,
  parameter int TOUT_TICKS = 450,
  parameter int VSRC_TICKS = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbus_ok_a,
  input  logic       dp_low_a,
  input  logic       dp_win_a,
  input  logic       dm_win_a,
  output logic       idp_src_en,
  output logic       vdp_src_en,
  output logic       vdm_src_en,
  output logic       chg_det,
  output logic       chg_allow_pull,
  output logic       sw_close_pull,
  output logic [1:0] port_type,
  output logic       det_done
);
  localparam int TW = bc_cnt_bits(bc_max2(TOUT_TICKS, VSRC_TICKS));
  localparam int DW = bc_cnt_bits(DBNC_TICKS);
  localparam logic [TW-1:0] TOUT_LAST = TW'(TOUT_TICKS - 1);
  localparam logic [TW-1:0] PROBE_LAST = TW'(VSRC_TICKS - 1);
  localparam logic [DW-1:0] DBNC_LAST = DW'(DBNC_TICKS - 1);

  // R1: re-timed comparator flags
  logic [3:0] flags_s;
  logic vbus_s, dp_low_s, dp_win_s, dm_win_s;

  bc_sync #(.WIDTH(4)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_a  ({vbus_ok_a, dp_low_a, dp_win_a, dm_win_a}),
    .q_s  (flags_s)
  );
  assign {vbus_s, dp_low_s, dp_win_s, dm_win_s} = flags_s;

  bc_state_t state_q, state_d;
  bc_port_t  pt_q, pt_d;
  logic      done_q, done_d;

  logic [TW-1:0] phase_cnt;
  logic [DW-1:0] dbnc_cnt;
  logic          phase_clr, dbnc_clr;

  // named internal events
  logic contact_seen, contact_tout, probe_end;

  bc_tick_counter #(.WIDTH(TW)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (phase_clr),
    .count(phase_cnt)
  );

  bc_tick_counter #(.WIDTH(DW)) u_dbnc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (dbnc_clr),
    .count(dbnc_cnt)
  );

  // R2: the run length restarts whenever the D+-low flag drops
  assign dbnc_clr     = !(state_q == ST_CONT && dp_low_s);
  assign contact_seen = (state_q == ST_CONT) && dp_low_s && (dbnc_cnt == DBNC_LAST);
  assign contact_tout = (state_q == ST_CONT) && (phase_cnt == TOUT_LAST);
  assign probe_end    = (phase_cnt == PROBE_LAST);
  assign phase_clr    = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    pt_d    = pt_q;
    done_d  = 1'b0;
    if (!vbus_s) begin
      state_d = ST_IDLE;
      pt_d    = PT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_CONT;
        ST_CONT: if (contact_seen || contact_tout) state_d = ST_PRI;
        ST_PRI: if (probe_end) begin
          if (dm_win_s) state_d = ST_SEC;
          else begin
            state_d = ST_FINAL;
            pt_d    = PT_STD;
            done_d  = 1'b1;
          end
        end
        ST_SEC: if (probe_end) begin
          state_d = ST_FINAL;
          pt_d    = dp_win_s ? PT_DED : PT_CHG;
          done_d  = 1'b1;
        end
        ST_FINAL: state_d = ST_FINAL;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pt_q    <= PT_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pt_q    <= pt_d;
      done_q  <= done_d;
    end
  end

  // all status outputs decode the same registers, so they move on one edge
  logic fin;
  assign fin            = (state_q == ST_FINAL);
  assign idp_src_en     = (state_q == ST_CONT);
  assign vdp_src_en     = (state_q == ST_PRI) || (fin && pt_q == PT_DED);
  assign vdm_src_en     = (state_q == ST_SEC);
  assign chg_det        = fin && bc_is_charger(pt_q);
  assign chg_allow_pull = fin;
  assign sw_close_pull  = fin && bc_closes_switch(pt_q);
  assign port_type      = pt_q;
  assign det_done       = done_q;

  assert_src_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idp_src_en, vdp_src_en, vdm_src_en}));

  assert_charger_permits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_det || sw_close_pull) |-> chg_allow_pull);

  assert_idle_before_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_type == 2'b00) |-> (!chg_det && !chg_allow_pull && !sw_close_pull));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |=> !det_done);

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_type != 2'b00 && vbus_s) |=> $stable(port_type));

  assert_vbus_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_s |=> (!idp_src_en && !vdp_src_en && !vdm_src_en && !chg_det &&
                 !chg_allow_pull && !sw_close_pull && port_type == 2'b00));

  assert_contact_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (contact_seen && !contact_tout && vbus_s) |=> vdp_src_en);

  assert_probe_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vdm_src_en && !$past(vdm_src_en)) |-> $past(vdp_src_en));
endmodule

// File: tb/tb_bc_charger_detect.sv
module tb_bc_charger_detect;
  localparam int DB = 10;
  localparam int TO = 450;
  localparam int VS = 40;
  localparam int SYNC_LAG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vbus_ok_a = 1'b0, dp_low_a = 1'b0, dp_win_a = 1'b0, dm_win_a = 1'b0;
  logic idp_src_en, vdp_src_en, vdm_src_en, chg_det, chg_allow_pull, sw_close_pull, det_done;
  logic [1:0] port_type;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit tog_en = 0;

  always #5 clk = ~clk;

  bc_charger_detect #(.DBNC_TICKS(DB), .TOUT_TICKS(TO), .VSRC_TICKS(VS)) dut (
    .clk(clk), .rst_n(rst_n), .vbus_ok_a(vbus_ok_a), .dp_low_a(dp_low_a),
    .dp_win_a(dp_win_a), .dm_win_a(dm_win_a), .idp_src_en(idp_src_en),
    .vdp_src_en(vdp_src_en), .vdm_src_en(vdm_src_en), .chg_det(chg_det),
    .chg_allow_pull(chg_allow_pull), .sw_close_pull(sw_close_pull),
    .port_type(port_type), .det_done(det_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {idp_src_en, vdp_src_en, vdm_src_en, chg_det, chg_allow_pull,
            sw_close_pull, port_type, det_done};
  endfunction

  task automatic detach();
    vbus_ok_a = 1'b0;
    repeat (SYNC_LAG) @(posedge clk);
    @(negedge clk);
    check(outs() == 0, "R9 all outputs cleared after VBUS loss", outs(), 0);
    dp_low_a = 0; dp_win_a = 0; dm_win_a = 0;
    repeat (3) @(negedge clk);
  endtask

  // one attach: apply pattern, count edges to completion, check outputs
  task automatic attach(input bit dpl, input bit dmw, input bit dpw, input bit toggle,
                        input logic [1:0] exp_pt, input int exp_lat, input string req);
    int n = 0;
    bit early_bad = 0;
    bit exp_chg, exp_sw, exp_vdp;
    logic [1:0] held;
    exp_chg = (exp_pt == 2'b10) || (exp_pt == 2'b11);
    exp_sw  = (exp_pt == 2'b01) || (exp_pt == 2'b10);
    exp_vdp = (exp_pt == 2'b11);
    @(negedge clk);
    dp_low_a = dpl; dm_win_a = dmw; dp_win_a = dpw;
    vbus_ok_a = 1'b1;
    if (toggle) begin
      tog_en = 1;
      fork
        begin
          while (tog_en) begin
            repeat (5) @(negedge clk);
            if (tog_en) dp_low_a = ~dp_low_a;
          end
        end
      join_none
    end
    while (n < 3000) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (det_done) break;
      if (chg_det || chg_allow_pull || sw_close_pull || port_type != 0) early_bad = 1;
      if (n == SYNC_LAG + 2)
        check(idp_src_en && !vdp_src_en && !vdm_src_en, "R1 contact detection current source on",
              idp_src_en, 1);
      if (!toggle && dpl && n == SYNC_LAG + DB + 1)
        check(vdp_src_en && !idp_src_en, "R4 primary probe drives D+ source", vdp_src_en, 1);
      if (!toggle && dpl && dmw && n == SYNC_LAG + DB + VS + 1)
        check(vdm_src_en && !vdp_src_en, "R5 secondary probe drives D- source", vdm_src_en, 1);
    end
    tog_en = 0;
    check(!early_bad, "R7 status inactive before completion", early_bad, 0);
    check(n == exp_lat, {req, " completion latency"}, n, exp_lat);
    check(port_type == exp_pt, {req, " port code"}, port_type, exp_pt);
    check(chg_det == exp_chg && sw_close_pull == exp_sw && chg_allow_pull &&
          vdp_src_en == exp_vdp && !vdm_src_en && !idp_src_en,
          "R6 status outputs for port code", {chg_det, sw_close_pull, chg_allow_pull, vdp_src_en},
          {exp_chg, exp_sw, 1'b1, exp_vdp});
    held = port_type;
    @(negedge clk);
    check(!det_done, "R8 done pulse lasts one cycle", det_done, 0);
    dp_low_a = ~dp_low_a; dm_win_a = ~dm_win_a; dp_win_a = ~dp_win_a;
    repeat (20) @(negedge clk);
    check(port_type == held, "R8 code held while VBUS valid", port_type, held);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(outs() == 0, "R7 reset state all inactive", outs(), 0);

    // R4 standard port: contact seen, D- window empty
    attach(1, 0, 0, 0, 2'b01, SYNC_LAG + DB + VS, "R4 standard port");
    detach();
    // R5 charging downstream port
    attach(1, 1, 0, 0, 2'b10, SYNC_LAG + DB + 2 * VS, "R5 charging downstream");
    detach();
    // R5 dedicated port, D+ source stays on
    attach(1, 1, 1, 0, 2'b11, SYNC_LAG + DB + 2 * VS, "R5 dedicated port");
    detach();
    // R3 no contact: timeout falls through to probing
    attach(0, 1, 0, 0, 2'b10, SYNC_LAG + TO + 2 * VS, "R3 timeout fall-through");
    detach();
    // R2 D+-low flag toggles faster than debounce: count restarts, timeout path
    attach(1, 0, 0, 1, 2'b01, SYNC_LAG + TO + VS, "R2 debounce restart");
    detach();

    // R9 VBUS loss in the middle of secondary probe
    @(negedge clk);
    dp_low_a = 1; dm_win_a = 1; vbus_ok_a = 1;
    repeat (SYNC_LAG + DB + VS + 5) @(negedge clk);
    check(vdm_src_en, "R9 setup secondary probe active", vdm_src_en, 1);
    detach();
    // R1 re-attach after loss starts over
    attach(1, 0, 0, 0, 2'b01, SYNC_LAG + DB + VS, "R1 restart after VBUS loss");
    detach();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule